// File: doc/BRIEF.md
# Amplifier Serial Control Register

This block is the digital control front end of a programmable-gain transmit amplifier. A host writes an 8-bit control word over a three-wire serial port. The port has an active-low select, a serial clock and a data line, and the word arrives most significant bit first. When the select line returns high, a completed word is committed into a storage latch. The latched word is decoded together with two hardware pins into the amplifier's control lines: a 6-bit attenuator gain code, an output-stage gain select, a transmit enable and an analog power enable. One pin enables transmission. The other, active low, powers the block down.

Everything runs on one system clock. The serial lines and both hardware pins each pass through a two-flop synchroniser, and the edges of the serial clock and the select line are found in the system clock domain. The system clock must run at least four times faster than the serial clock. A frame is committed only if it carried exactly eight bits. A frame of any other length is dropped.

Top module: `amp_serial_ctl`

## Requirements
- R1: While `ser_sel_n` is low, one bit of `ser_dat` is taken on each rising edge of `ser_clk`. The first bit taken becomes bit 7 of the control word.
- R2: A new word reaches the outputs only after `ser_sel_n` rises. During a frame, and after all 8 bits have arrived but before the select rises, the outputs keep their previous values.
- R3: `gain_code` equals bits 5..0 of the latched word, and it is visible whenever `pwr_on` is high, including during software shutdown.
- R4: `hi_gain` equals latched bit 6 (1 = high-gain stage, 0 = low-noise stage) while `pwr_on` is high.
- R5: `tx_on` is high only when `hw_tx_en` is high, latched bit 7 is 1 and `pwr_on` is high.
- R6: Latched bits 7..6 = 00 is software shutdown. In this state `analog_pwr` and `tx_on` are 0 and `gain_code` still shows the stored gain.
- R7: With `hw_tx_en` high, bits 7..6 decode as follows. 01 gives transmit disabled with `analog_pwr`=1 and `tx_on`=0. 10 gives low-noise transmit with `tx_on`=1 and `hi_gain`=0. 11 gives high-power transmit with `tx_on`=1 and `hi_gain`=1.
- R8: While `pwr_on` is low, every output is 0 and serial traffic is ignored. The stored word is cleared to 0x00, so it stays 0x00 when power returns.
- R9: A frame with a bit count other than 8 leaves the latch unchanged. The bit count restarts at every falling edge of `ser_sel_n`.
- R10: After reset the latch holds 0x00, which is software shutdown with gain code 0, and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_sel_n | input | 1 | Serial select, active low, frames a write |
| ser_clk | input | 1 | Serial clock, data taken on rising edge |
| ser_dat | input | 1 | Serial data, MSB first |
| hw_tx_en | input | 1 | Hardware transmit enable pin |
| pwr_on | input | 1 | Hardware power pin, low = full shutdown |
| gain_code | output | 6 | Attenuator gain code |
| hi_gain | output | 1 | Output stage select: 1 high-gain, 0 low-noise |
| tx_on | output | 1 | Transmit enable to the amplifier |
| analog_pwr | output | 1 | Analog circuitry power enable |

## Verification
A word commit, triggered by the select rising, can land in the same system cycle as the power pin falling. Both signals pass through synchronisers of equal depth. The bench therefore changes `ser_sel_n` to high and `pwr_on` to low at the same instant at the end of a valid frame, and the two events meet in the same cycle. Shutdown must win: the word must not survive, and the outputs must read 0 both during shutdown and after power returns.

// File: rtl/amp_ctl_pkg.sv
package amp_ctl_pkg;
    localparam int WORD_W = 8;
    localparam int GAIN_W = 6;
    localparam int CNT_W  = $clog2(WORD_W + 2);

    typedef struct packed {
        logic              analog_pwr;
        logic              tx_on;
        logic              hi_gain;
        logic [GAIN_W-1:0] gain;
    } ctl_out_t;

    typedef struct packed {
        logic [WORD_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] word;
        logic              sel_p;
        logic              sclk_p;
    } shift_st_t;
endpackage

// File: rtl/amp_sync.sv
module amp_sync #(
    parameter int          WIDTH  = 1,
    parameter int          STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                chain_q[s] <= RST_VAL;
            end
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/amp_shift.sv
module amp_shift
    import amp_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_s,
    input  logic              sel_s,
    input  logic              sclk_s,
    input  logic              dat_s,
    output logic [WORD_W-1:0] word_q,
    output logic              commit_stb
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

    shift_st_t st_d, st_q;
    logic sel_fall, sel_rise, sclk_rise;

    always_comb begin
        st_d       = st_q;
        st_d.sel_p  = sel_s;
        st_d.sclk_p = sclk_s;
        sel_fall   = !sel_s && st_q.sel_p;
        sel_rise   = sel_s && !st_q.sel_p;
        sclk_rise  = sclk_s && !st_q.sclk_p;
        commit_stb = 1'b0;
        if (!pwr_s) begin
            st_d.shreg = '0;
            st_d.cnt   = '0;
            st_d.word  = '0;
        end else begin
            if (sel_fall) begin
                st_d.cnt = '0;
            end else if (!sel_s && sclk_rise) begin
                st_d.shreg = {st_q.shreg[WORD_W-2:0], dat_s};
                if (st_q.cnt != CNT_SAT) begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            if (sel_rise && st_q.cnt == CNT_FULL) begin
                st_d.word  = st_q.shreg;
                commit_stb = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.shreg  <= '0;
            st_q.cnt    <= '0;
            st_q.word   <= '0;
            st_q.sel_p  <= 1'b1;
            st_q.sclk_p <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_q = st_q.word;
endmodule

// File: rtl/amp_decode.sv
module amp_decode
    import amp_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_s,
    input  logic              txen_s,
    input  logic [WORD_W-1:0] word_q,
    output ctl_out_t          out_q
);
    localparam int B_TX = WORD_W - 1;
    localparam int B_HG = WORD_W - 2;

    ctl_out_t out_d;

    always_comb begin
        out_d = '0;
        if (pwr_s) begin
            out_d.gain       = word_q[GAIN_W-1:0];
            out_d.hi_gain    = word_q[B_HG];
            out_d.analog_pwr = word_q[B_TX] || word_q[B_HG];
            out_d.tx_on      = word_q[B_TX] && txen_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end
endmodule

// File: rtl/amp_serial_ctl.sv
module amp_serial_ctl
    import amp_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_sel_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              hw_tx_en,
    input  logic              pwr_on,
    output logic [GAIN_W-1:0] gain_code,
    output logic              hi_gain,
    output logic              tx_on,
    output logic              analog_pwr
);
    logic [4:0]        pins_s;
    logic              pwr_s, txen_s, sel_s, sclk_s, dat_s;
    logic [WORD_W-1:0] word_q;
    logic              commit_stb;
    ctl_out_t          out_q;

    amp_sync #(.WIDTH(5), .STAGES(2), .RST_VAL(5'b00100)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({pwr_on, hw_tx_en, ser_sel_n, ser_clk, ser_dat}),
        .sync_o (pins_s)
    );
    assign {pwr_s, txen_s, sel_s, sclk_s, dat_s} = pins_s;

    amp_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_s     (pwr_s),
        .sel_s     (sel_s),
        .sclk_s    (sclk_s),
        .dat_s     (dat_s),
        .word_q    (word_q),
        .commit_stb(commit_stb)
    );

    amp_decode u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .pwr_s (pwr_s),
        .txen_s(txen_s),
        .word_q(word_q),
        .out_q (out_q)
    );

    assign gain_code  = out_q.gain;
    assign hi_gain    = out_q.hi_gain;
    assign tx_on      = out_q.tx_on;
    assign analog_pwr = out_q.analog_pwr;
endmodule

// File: rtl/amp_serial_ctl_chk.sv
module amp_serial_ctl_chk
    import amp_ctl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_s,
    input logic              commit_stb,
    input logic [WORD_W-1:0] word_q,
    input logic [GAIN_W-1:0] gain_code,
    input logic              hi_gain,
    input logic              tx_on,
    input logic              analog_pwr
);
    AST_TX_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        tx_on |-> analog_pwr); // R5

    AST_HIGAIN_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        hi_gain |-> analog_pwr); // R4

    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_s && !commit_stb) |=> $stable(word_q)); // R2

    AST_LATCH_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_s |=> (word_q == '0)); // R8

    AST_OFF_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pwr_s) |-> (!analog_pwr && !tx_on && !hi_gain && gain_code == '0)); // R8
endmodule

bind amp_serial_ctl amp_serial_ctl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_s     (pwr_s),
    .commit_stb(commit_stb),
    .word_q    (word_q),
    .gain_code (gain_code),
    .hi_gain   (hi_gain),
    .tx_on     (tx_on),
    .analog_pwr(analog_pwr)
);

// File: tb/amp_serial_ctl_test.sv
`timescale 1ns/1ps
module amp_serial_ctl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_sel_n = 1'b1, ser_clk = 1'b0, ser_dat = 1'b0;
    logic       hw_tx_en = 1'b0, pwr_on = 1'b1;
    logic [5:0] gain_code;
    logic       hi_gain, tx_on, analog_pwr;

    int n_chk = 0, n_bad = 0;
    logic [7:0] exp_word = 8'h00;
    bit done = 0;

    always #5 clk = ~clk;

    amp_serial_ctl uut (
        .clk(clk), .rst_n(rst_n), .ser_sel_n(ser_sel_n), .ser_clk(ser_clk),
        .ser_dat(ser_dat), .hw_tx_en(hw_tx_en), .pwr_on(pwr_on),
        .gain_code(gain_code), .hi_gain(hi_gain), .tx_on(tx_on), .analog_pwr(analog_pwr)
    );

    // Expected {analog_pwr, tx_on, hi_gain, gain[5:0]} from the requirements
    function automatic logic [8:0] model(logic [7:0] w, logic tx, logic pw);
        if (!pw) return 9'h000;
        return {(w[7] | w[6]), (w[7] & tx), w[6], w[5:0]};
    endfunction

    task automatic check(string req);
        logic [8:0] act, exp;
        act = {analog_pwr, tx_on, hi_gain, gain_code};
        exp = model(exp_word, hw_tx_en, pwr_on);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    // Shift nbits (word MSB first, then zeros); optionally leave select low
    task automatic shift_bits(logic [7:0] w, int nbits);
        @(negedge clk);
        ser_sel_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            ser_dat = (i < 8) ? w[7-i] : 1'b0;
            repeat (5) @(negedge clk);
            ser_clk = 1'b1;
            repeat (5) @(negedge clk);
            ser_clk = 1'b0;
        end
        repeat (5) @(negedge clk);
    endtask

    task automatic send(logic [7:0] w, int nbits);
        shift_bits(w, nbits);
        ser_sel_n = 1'b1;
        if (nbits == 8 && pwr_on) exp_word = w;
        settle();
    endtask

    task automatic set_pwr(logic v);
        @(negedge clk);
        pwr_on = v;
        if (!v) exp_word = 8'h00;
        settle();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7321));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        settle();
        check("R10 reset state");

        hw_tx_en = 1'b1;
        send(8'hFD, 8);
        check("R1 msb-first high-power word");

        shift_bits(8'h9E, 8);
        check("R2 no change before select rises");
        ser_sel_n = 1'b1;
        exp_word = 8'h9E;
        settle();
        check("R2 commit on select rise");

        send(8'hC0, 8);  check("R3 gain zero");
        send(8'h3F, 8);  check("R3 gain max in shutdown");
        send(8'h4A, 8);  check("R7 transmit disabled");
        send(8'h8C, 8);  check("R7 low-noise transmit");
        send(8'hE1, 8);  check("R4 high-gain select");

        @(negedge clk); hw_tx_en = 1'b0; settle();
        check("R5 pin low blocks transmit");
        @(negedge clk); hw_tx_en = 1'b1; settle();
        check("R5 pin high restores transmit");

        send(8'h15, 8);  check("R6 software shutdown keeps gain");
        send(8'hFF, 7);  check("R9 short frame dropped");
        send(8'h81, 9);  check("R9 long frame dropped");
        send(8'hB3, 8);  check("R9 next full frame accepted");

        set_pwr(1'b0);   check("R8 outputs off when powered down");
        send(8'hDD, 8);  check("R8 serial ignored when powered down");
        set_pwr(1'b1);   check("R8 word lost after power returns");

        // Commit and power-down meeting in the same cycle
        send(8'hC7, 8);
        shift_bits(8'h9B, 8);
        ser_sel_n = 1'b1;
        pwr_on = 1'b0;
        exp_word = 8'h00;
        settle();
        check("R8 shutdown wins over commit");
        set_pwr(1'b1);
        check("R8 no word survives coincident commit");

        for (int k = 0; k < 60; k++) begin
            logic [7:0] w;
            int sel, nb;
            w = 8'($urandom);
            sel = $urandom % 10;
            nb = (sel == 0) ? 7 : ((sel == 1) ? 9 : 8);
            @(negedge clk); hw_tx_en = 1'($urandom);
            if (sel == 2) begin
                set_pwr(1'b0);
                set_pwr(1'b1);
            end
            send(w, nb);
            if (nb != 8) check("R9 random ragged frame");
            else if (w[7:6] == 2'b00) check("R6 random shutdown word");
            else check("R7 random state word");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule